// File: doc/BRIEF.md
# Addressed Serial Command Receiver with Acknowledge

This block sits on the peripheral side of a three-wire host link made of an attention line, a host-driven serial clock and one data wire shared in both directions. The data wire appears at the block's edge as a separate input, an output and an output enable. A rising attention line arms the receiver, which then shifts in one command byte. The byte carries a module address in its upper nibble and a command in its lower nibble. The lowest bit of the command is a fixed marker that must be 1, and the three bits above it select a function option.

The byte is accepted only if its address matches the address strapped at the pins, the marker is set, and the option is enabled by parameter. Some options, chosen by a second parameter, need a further parameter byte that carries a repetition count and a starting channel. Once the command, and its parameter byte where one is needed, is complete, the block pulses a strobe with the decoded option and parameter. It then waits a fixed number of clock cycles for the host to turn the data wire around, and drives the command byte back as an acknowledge code that the host clocks out. A rejected byte leaves the data wire undriven, and the block goes back to idle until the attention line rises again. All three host lines are synchronized into the local clock domain, so host clock edges are seen a few cycles late.

Top module: `cmdrx`

## Requirements
- R1: The block takes in bits only after a rising edge of the attention line. Host clock pulses given while the receiver is not armed produce no strobe and never enable the data output.
- R2: Each byte is 8 bits, received least significant bit first. A bit is captured at the host clock's rising edge; the host changes data on its falling edge.
- R3: In the command byte, bits [7:4] are the address and bits [3:0] the command. Command bit 0 is the marker and must be 1. The option number is bits [3:1].
- R4: A command byte is accepted only if its address equals `strap_addr_i` and its option is enabled in OPT_VALID (default: options 0, 1 and 2, which are command nibbles 4'h1, 4'h3 and 4'h5). A rejected byte gives no strobe, leaves `sdata_oe_o` low and returns the block to idle.
- R5: Options flagged in OPT_PARAM (default: options 1 and 2) take a second byte. The strobe comes only after that byte, with `cmd_param_o` equal to it. Other accepted options strobe right after the command byte.
- R6: After an accepted command, the block waits TURN_CYC clock cycles after the last received bit. It then raises `sdata_oe_o` and presents the acknowledge code, which equals the accepted command byte. The output is never enabled outside an acknowledge.
- R7: The acknowledge is sent least significant bit first. Each new bit appears after a host falling clock edge and is held until the next one. After the 8th falling edge, `sdata_oe_o` goes low.
- R8: A low attention line aborts a transfer at any point. It disables the output, and the next arming starts again from bit 0 of a command byte.
- R9: After reset, `sdata_oe_o` and `cmd_stb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr_i | input | ADDR_W | Strapped module address |
| attn_i | input | 1 | Attention line from host |
| sclk_i | input | 1 | Host serial clock |
| sdata_i | input | 1 | Data wire, host to block |
| sdata_o | output | 1 | Data wire, block to host |
| sdata_oe_o | output | 1 | Drive enable for the data wire |
| cmd_stb_o | output | 1 | One-cycle pulse for a complete accepted command |
| cmd_opt_o | output | CMD_W-1 | Decoded option number |
| cmd_param_o | output | ADDR_W+CMD_W | Parameter byte, zero if the option takes none |

## Verification
The main path is tried with several command bytes:
- A plain option (0xA1) and two options that take a parameter (0xA3, 0xA5), so that a wrong nibble split or a reversed bit order shows up in both the strobe and the acknowledge bits read back.
- Three rejected bytes: one with a wrong address, one with the marker cleared and one with a disabled option. Each condition is told apart from the others, and each must leave the data output undriven.
- Aborts in the middle of a command and in the middle of an acknowledge, which test whether the bit counter and the output are cleared.
- Clock pulses before arming, which test whether the receiver starts too early.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX_CMD,
      ST_RX_PARAM,
      ST_TURN,
      ST_TX
   } cmdrx_state_e;
endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cmdrx_rx_shift.sv
module cmdrx_rx_shift #(
   parameter int W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         sample_i,
   input  logic         din_i,
   output logic         done_o,
   output logic [W-1:0] byte_o
);
   localparam int CNT_W = $clog2(W + 1);

   logic [W-1:0]     shreg;
   logic [CNT_W-1:0] cnt;

   // LSB first: new bit enters at the top and moves down
   assign byte_o = {din_i, shreg[W-1:1]};
   assign done_o = sample_i && !clr_i && (cnt == CNT_W'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (clr_i) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (sample_i) begin
         shreg <= byte_o;
         cnt   <= done_o ? '0 : cnt + 1'b1;
      end
   end

   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(W));
   p_clr_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt == '0));
endmodule

// File: rtl/cmdrx_decode.sv
module cmdrx_decode #(
   parameter int ADDR_W = 4,
   parameter int CMD_W  = 4,
   parameter logic [2**(CMD_W-1)-1:0] OPT_VALID = '1,
   parameter logic [2**(CMD_W-1)-1:0] OPT_PARAM = '0,
   parameter bit ADDR_CHECK = 1'b1
)(
   input  logic [ADDR_W+CMD_W-1:0] byte_i,
   input  logic [ADDR_W-1:0]       strap_i,
   output logic                    accept_o,
   output logic                    param_o,
   output logic [CMD_W-2:0]        opt_o
);
   localparam int BYTE_W = ADDR_W + CMD_W;

   logic addr_ok;
   logic marker_ok;

   generate
      if (ADDR_CHECK) begin : g_addr_cmp
         assign addr_ok = (byte_i[BYTE_W-1:CMD_W] == strap_i);
      end else begin : g_addr_any
         assign addr_ok = 1'b1;
      end
   endgenerate

   assign marker_ok = byte_i[0];
   assign opt_o     = byte_i[CMD_W-1:1];
   assign accept_o  = addr_ok && marker_ok && OPT_VALID[opt_o];
   assign param_o   = OPT_PARAM[opt_o];
endmodule

// File: rtl/cmdrx_tx_shift.sv
module cmdrx_tx_shift #(
   parameter int W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         load_i,
   input  logic [W-1:0] code_i,
   input  logic         shift_i,
   output logic         sdo_o,
   output logic         oe_o
);
   localparam int CNT_W = $clog2(W + 1);

   logic [W-1:0]     shreg;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
         oe_o  <= 1'b0;
      end else if (clr_i) begin
         shreg <= '0;
         cnt   <= '0;
         oe_o  <= 1'b0;
      end else if (load_i) begin
         shreg <= code_i;
         cnt   <= '0;
         oe_o  <= 1'b1;
      end else if (shift_i && oe_o) begin
         if (cnt == CNT_W'(W - 1)) begin
            oe_o <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
         shreg <= {1'b0, shreg[W-1:1]};
      end
   end

   assign sdo_o = shreg[0];

   p_hold_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_o && !shift_i && !load_i && !clr_i) |=> $stable(sdo_o));
   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_o && shift_i && !clr_i && !load_i && cnt == CNT_W'(W - 1)) |=> !oe_o);
endmodule

// File: rtl/cmdrx.sv
module cmdrx
   import cmdrx_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int CMD_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int TURN_CYC    = 32,
   parameter logic [2**(CMD_W-1)-1:0] OPT_VALID = 'h07,
   parameter logic [2**(CMD_W-1)-1:0] OPT_PARAM = 'h06,
   parameter bit ADDR_CHECK  = 1'b1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       strap_addr_i,
   input  logic                    attn_i,
   input  logic                    sclk_i,
   input  logic                    sdata_i,
   output logic                    sdata_o,
   output logic                    sdata_oe_o,
   output logic                    cmd_stb_o,
   output logic [CMD_W-2:0]        cmd_opt_o,
   output logic [ADDR_W+CMD_W-1:0] cmd_param_o
);
   localparam int BYTE_W = ADDR_W + CMD_W;
   localparam int OPT_W  = CMD_W - 1;
   localparam int TURN_W = $clog2(TURN_CYC + 1);

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("cmdrx: SYNC_STAGES must be at least 2");
      end
      if (CMD_W < 2) begin : g_chk_cmd
         $error("cmdrx: CMD_W must leave room for marker and option");
      end
      if (TURN_CYC < 1) begin : g_chk_turn
         $error("cmdrx: TURN_CYC must be positive");
      end
      if ((OPT_PARAM & ~OPT_VALID) != '0) begin : g_chk_mask
         $error("cmdrx: OPT_PARAM flags an option that is not valid");
      end
   endgenerate

   // synchronized host lines
   logic [2:0] sync_q;
   logic       attn_s, sclk_s, sdata_s;
   logic       attn_d, sclk_d;

   cmdrx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({attn_i, sclk_i, sdata_i}),
      .q_o   (sync_q)
   );
   assign {attn_s, sclk_s, sdata_s} = sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attn_d <= 1'b0;
         sclk_d <= 1'b0;
      end else begin
         attn_d <= attn_s;
         sclk_d <= sclk_s;
      end
   end

   logic attn_rise, sclk_rise, sclk_fall;
   assign attn_rise = attn_s && !attn_d;
   assign sclk_rise = sclk_s && !sclk_d;
   assign sclk_fall = !sclk_s && sclk_d;

   cmdrx_state_e       state;
   logic [BYTE_W-1:0]  cmd_q, param_q;
   logic [OPT_W-1:0]   opt_q;
   logic               stb_q;
   logic [TURN_W-1:0]  turn_cnt;

   // receive path
   logic              rx_clr, rx_sample, rx_done;
   logic [BYTE_W-1:0] rx_byte;

   assign rx_clr    = !attn_s || (state == ST_IDLE);
   assign rx_sample = sclk_rise && ((state == ST_RX_CMD) || (state == ST_RX_PARAM));

   cmdrx_rx_shift #(.W(BYTE_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (rx_clr),
      .sample_i (rx_sample),
      .din_i    (sdata_s),
      .done_o   (rx_done),
      .byte_o   (rx_byte)
   );

   // decode
   logic             dec_accept, dec_param;
   logic [OPT_W-1:0] dec_opt;

   cmdrx_decode #(
      .ADDR_W     (ADDR_W),
      .CMD_W      (CMD_W),
      .OPT_VALID  (OPT_VALID),
      .OPT_PARAM  (OPT_PARAM),
      .ADDR_CHECK (ADDR_CHECK)
   ) u_dec (
      .byte_i   (rx_byte),
      .strap_i  (strap_addr_i),
      .accept_o (dec_accept),
      .param_o  (dec_param),
      .opt_o    (dec_opt)
   );

   // acknowledge path
   logic tx_load, tx_shift, tx_oe, tx_sdo;
   logic turn_end;

   assign turn_end = (turn_cnt == TURN_W'(TURN_CYC - 1));
   assign tx_load  = attn_s && (state == ST_TURN) && turn_end;
   assign tx_shift = sclk_fall && (state == ST_TX);

   cmdrx_tx_shift #(.W(BYTE_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (!attn_s),
      .load_i  (tx_load),
      .code_i  (cmd_q),
      .shift_i (tx_shift),
      .sdo_o   (tx_sdo),
      .oe_o    (tx_oe)
   );

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cmd_q    <= '0;
         param_q  <= '0;
         opt_q    <= '0;
         stb_q    <= 1'b0;
         turn_cnt <= '0;
      end else begin
         stb_q <= 1'b0;
         if (!attn_s) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_IDLE: begin
                  if (attn_rise) state <= ST_RX_CMD;
               end
               ST_RX_CMD: begin
                  if (rx_done) begin
                     if (dec_accept) begin
                        cmd_q   <= rx_byte;
                        opt_q   <= dec_opt;
                        param_q <= '0;
                        if (dec_param) begin
                           state <= ST_RX_PARAM;
                        end else begin
                           stb_q    <= 1'b1;
                           turn_cnt <= '0;
                           state    <= ST_TURN;
                        end
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_RX_PARAM: begin
                  if (rx_done) begin
                     param_q  <= rx_byte;
                     stb_q    <= 1'b1;
                     turn_cnt <= '0;
                     state    <= ST_TURN;
                  end
               end
               ST_TURN: begin
                  if (turn_end) state <= ST_TX;
                  else          turn_cnt <= turn_cnt + 1'b1;
               end
               ST_TX: begin
                  if (!tx_oe) state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign sdata_o     = tx_sdo;
   assign sdata_oe_o  = tx_oe;
   assign cmd_stb_o   = stb_q;
   assign cmd_opt_o   = opt_q;
   assign cmd_param_o = param_q;

   p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !attn_s |=> (state == ST_IDLE) && !sdata_oe_o);
   p_oe_after_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdata_oe_o) |-> ($past(state) == ST_TURN));
   p_stb_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb_o |-> cmd_q[0] &&
         (!ADDR_CHECK || cmd_q[BYTE_W-1:CMD_W] == strap_addr_i));
   p_stb_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb_o |=> !cmd_stb_o);
endmodule

// File: tb/cmdrx_bench.sv
module cmdrx_bench;
   localparam int H = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] strap = 4'hA;
   logic       attn = 1'b0, sclk = 1'b0, sdata = 1'b0;
   logic       sdo, oe, stb;
   logic [2:0] opt;
   logic [7:0] prm;

   always #5 clk = ~clk;

   cmdrx u_cmdrx (
      .clk          (clk),
      .rst_n        (rst_n),
      .strap_addr_i (strap),
      .attn_i       (attn),
      .sclk_i       (sclk),
      .sdata_i      (sdata),
      .sdata_o      (sdo),
      .sdata_oe_o   (oe),
      .cmd_stb_o    (stb),
      .cmd_opt_o    (opt),
      .cmd_param_o  (prm)
   );

   int vecs = 0, errs = 0, spill = 0;
   logic       stb_seen = 1'b0, clr_seen = 1'b0, oe_allow = 1'b0;
   logic [2:0] seen_opt = '0;
   logic [7:0] seen_prm = '0;

   always @(posedge clk) begin
      if (clr_seen) stb_seen <= 1'b0;
      else if (stb) begin
         stb_seen <= 1'b1;
         seen_opt <= opt;
         seen_prm <= prm;
      end
   end

   // every clock: output enable only inside an expected acknowledge window
   always @(negedge clk) if (rst_n && oe && !oe_allow) spill++;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_seen();
      clr_seen = 1'b1;
      wait_clk(1);
      clr_seen = 1'b0;
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         sdata = b[i];
         wait_clk(H);
         sclk = 1'b1;
         wait_clk(H);
         sclk = 1'b0;
      end
   endtask

   task automatic arm();
      clear_seen();
      attn = 1'b1;
      wait_clk(6);
   endtask

   task automatic disarm();
      attn = 1'b0;
      wait_clk(6);
   endtask

   task automatic read_ack(input logic [7:0] exp, input int nbits);
      wait_clk(10);
      chk(!oe, "R6 output enabled before turnaround", int'(oe), 0);
      oe_allow = 1'b1;
      wait_clk(40);
      for (int k = 0; k < nbits; k++) begin
         chk(oe && sdo == exp[k], $sformatf("R7 ack bit %0d", k), int'({oe, sdo}), int'({1'b1, exp[k]}));
         sclk = 1'b1;
         wait_clk(H);
         sclk = 1'b0;
         wait_clk(H);
      end
      if (nbits == 8) chk(!oe, "R7 release after last bit", int'(oe), 0);
   endtask

   task automatic reject_case(input logic [7:0] b, input string tag);
      arm();
      send_bits(b, 8);
      wait_clk(60);
      chk(!stb_seen && !oe, tag, int'({stb_seen, oe}), 0);
      disarm();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      wait_clk(4);
      chk(!oe && !stb, "R9 reset outputs", int'({oe, stb}), 0);
      rst_n = 1'b1;
      wait_clk(4);

      // R1: clocking while unarmed
      send_bits(8'hA1, 8);
      wait_clk(60);
      chk(!stb_seen && !oe, "R1 unarmed clocks ignored", int'({stb_seen, oe}), 0);

      // R2 R3 R6 R7: plain option 0
      arm();
      send_bits(8'hA1, 8);
      chk(stb_seen && seen_opt == 3'd0 && seen_prm == 8'h00, "R3 strobe opt0",
          int'({seen_opt, seen_prm}), 0);
      read_ack(8'hA1, 8);
      oe_allow = 1'b0;
      disarm();

      // R5: option 1 with parameter byte
      arm();
      send_bits(8'hA3, 8);
      chk(!stb_seen, "R5 no strobe before param", int'(stb_seen), 0);
      send_bits(8'h5C, 8);
      chk(stb_seen && seen_opt == 3'd1 && seen_prm == 8'h5C, "R5 strobe with param",
          int'({seen_opt, seen_prm}), int'({3'd1, 8'h5C}));
      read_ack(8'hA3, 8);
      oe_allow = 1'b0;
      disarm();

      // R4 / R3 rejections
      reject_case(8'hB1, "R4 address mismatch");
      reject_case(8'hA2, "R3 marker clear");
      reject_case(8'hA7, "R4 disabled option");

      // R8: abort mid command, then option 2 with param
      arm();
      send_bits(8'hFF, 4);
      disarm();
      arm();
      send_bits(8'hA5, 8);
      chk(!stb_seen, "R8 restart no early strobe", int'(stb_seen), 0);
      send_bits(8'h81, 8);
      chk(stb_seen && seen_opt == 3'd2 && seen_prm == 8'h81, "R8 restart from bit 0",
          int'({seen_opt, seen_prm}), int'({3'd2, 8'h81}));
      read_ack(8'hA5, 8);
      oe_allow = 1'b0;
      disarm();

      // R8: abort during acknowledge
      strap = 4'h5;
      wait_clk(4);
      arm();
      send_bits(8'h51, 8);
      read_ack(8'h51, 2);
      attn = 1'b0;
      wait_clk(6);
      chk(!oe, "R8 abort drops output", int'(oe), 0);
      oe_allow = 1'b0;
      wait_clk(6);

      chk(spill == 0, "R6 output enabled outside window", spill, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule